// File: doc/BRIEF.md
# Access Permission and Fault Checker

This block sits behind a translation buffer and judges each memory access. The inputs are the lookup result (a hit flag, the page attribute bits and the physical address) plus the access itself: virtual address, size, direction, privilege mode, whether the translation is real, and whether the access uses a no-fault address space. Each request gets one registered response. The response says either that the access may go ahead or which single fault stops it. A permitted access is also marked uncacheable when its page or its physical address calls for it.

The checks run in a fixed order, and the first failing check names the fault. The order is: alignment, miss, privilege, write protection, no-fault-only page, and side effect. Any fault also loads a tag-access register with the faulting virtual page number and the context, so that a miss or fault handler can read them. The lookup itself and the delivery of the trap are handled by other blocks.

Top module: `acc_fault_chk`

## Requirements
- R1: A request whose virtual address is not a multiple of its byte count (size_i is log2 of the byte count: 0 means 1 byte, 3 means 8 bytes) gets fault code 1 (alignment). This holds whatever the hit flag and the attributes are.
- R2: An aligned request with hit_i low gets fault code 2 when real_i is high and fault code 3 when real_i is low.
- R3: An aligned hit with priv_i low on a page whose attribute bit 0 (privileged) is set gets fault code 4. This check comes before every later check.
- R4: An aligned hit that passes R3, with write_i high, on a page whose attribute bit 1 (writable) is clear gets fault code 5.
- R5: An aligned hit that passes R3 and R4, with nf_asi_i low, on a page whose attribute bit 2 (no-fault-only) is set gets fault code 6. With nf_asi_i high, that bit causes no fault.
- R6: An aligned hit that passes R3 to R5, with nf_asi_i high, on a page whose attribute bit 3 (side effect) is set gets fault code 7. A request that passes every check gets code 0.
- R7: uncache_o is high in a response with code 0 when attribute bit 3 is set or pa_i bit 39 is set. In every other response uncache_o is low.
- R8: On every response with a nonzero code, tag_access_o takes the value {va_i[63:13], ctx_i[12:0]} from the request. Responses with code 0 leave tag_access_o unchanged.
- R9: Every response appears one clock after the request, with rsp_valid_o high for that one cycle. In the response, fault_vec_o bit (code-1) is the only bit set, and fault_vec_o is all zeros for code 0. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| va_i | input | 64 | Virtual address |
| size_i | input | 2 | log2 of the access byte count |
| write_i | input | 1 | Store access |
| real_i | input | 1 | Real (untranslated-context) translation |
| nf_asi_i | input | 1 | Access uses a no-fault address space |
| priv_i | input | 1 | Access is made in privileged mode |
| hit_i | input | 1 | Translation lookup hit |
| attr_i | input | 4 | Page attributes: [0] privileged, [1] writable, [2] no-fault-only, [3] side effect |
| pa_i | input | 40 | Physical address from the hit entry |
| ctx_i | input | 13 | Context of the access |
| rsp_valid_o | output | 1 | Response valid |
| fault_code_o | output | 3 | Fault code, 0 = none |
| fault_vec_o | output | 7 | One-hot fault flags, bit n for code n+1 |
| uncache_o | output | 1 | Permitted access is uncacheable |
| tag_access_o | output | 64 | Captured faulting page and context |

## Verification
The hardest cases to produce are the ones where several faults apply at once, because only the fault with the highest priority may show up. The stimulus table therefore includes requests that set the privileged and read-only bits together, the read-only and no-fault-only bits together, and a physical address with bit 39 set on a faulting access. The tag register is checked after every row, so that a permitted access between two faults shows that the register keeps its value.

// File: rtl/acc_fault_pkg.sv
package acc_fault_pkg;
  localparam int NUM_FAULTS = 7;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ALIGN  = 3'd1,
    FLT_MISS_R = 3'd2,
    FLT_MISS_V = 3'd3,
    FLT_PRIV   = 3'd4,
    FLT_PROT   = 3'd5,
    FLT_NFO    = 3'd6,
    FLT_SIDE   = 3'd7
  } fault_e;

  localparam int ATTR_PRIV = 0;
  localparam int ATTR_WR   = 1;
  localparam int ATTR_NFO  = 2;
  localparam int ATTR_SIDE = 3;
endpackage

// File: rtl/acc_align_chk.sv
module acc_align_chk #(
  parameter int SZ_W = 2
) (
  input  logic [(2**SZ_W)-2:0] va_lo_i,
  input  logic [SZ_W-1:0]      size_i,
  output logic                 misaligned_o
);
  localparam int LO_W = (2**SZ_W) - 1;
  logic [LO_W-1:0] mask;
  // wraps to all ones for the widest size
  assign mask = (LO_W'(1) << size_i) - LO_W'(1);
  assign misaligned_o = |(va_lo_i & mask);
endmodule

// File: rtl/acc_perm_chk.sv
module acc_perm_chk
  import acc_fault_pkg::*;
(
  input  logic       misaligned_i,
  input  logic       hit_i,
  input  logic       real_i,
  input  logic       priv_i,
  input  logic       write_i,
  input  logic       nf_asi_i,
  input  logic [3:0] attr_i,
  output fault_e     code_o
);
  always_comb begin
    if (misaligned_i)                               code_o = FLT_ALIGN;
    else if (!hit_i)                                code_o = real_i ? FLT_MISS_R : FLT_MISS_V;
    else if (!priv_i && attr_i[ATTR_PRIV])          code_o = FLT_PRIV;
    else if (write_i && !attr_i[ATTR_WR])           code_o = FLT_PROT;
    else if (!nf_asi_i && attr_i[ATTR_NFO])         code_o = FLT_NFO;
    else if (nf_asi_i && attr_i[ATTR_SIDE])         code_o = FLT_SIDE;
    else                                            code_o = FLT_NONE;
  end
endmodule

// File: rtl/acc_tag_reg.sv
module acc_tag_reg #(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 13,
  parameter int CTX_W    = 13
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [VA_W-1:0]                  va_i,
  input  logic [CTX_W-1:0]                 ctx_i,
  output logic [VA_W-PG_SHIFT+CTX_W-1:0]   tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tag_o <= '0;
    else if (load_i) tag_o <= {va_i[VA_W-1:PG_SHIFT], ctx_i};
  end
endmodule

// File: rtl/acc_fault_chk.sv
module acc_fault_chk
  import acc_fault_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 40,
  parameter int CTX_W    = 13,
  parameter int PG_SHIFT = 13,
  parameter int SZ_W     = 2,
  parameter int UC_BIT   = 39
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic [VA_W-1:0]                va_i,
  input  logic [SZ_W-1:0]                size_i,
  input  logic                           write_i,
  input  logic                           real_i,
  input  logic                           nf_asi_i,
  input  logic                           priv_i,
  input  logic                           hit_i,
  input  logic [3:0]                     attr_i,
  input  logic [PA_W-1:0]                pa_i,
  input  logic [CTX_W-1:0]               ctx_i,
  output logic                           rsp_valid_o,
  output logic [2:0]                     fault_code_o,
  output logic [NUM_FAULTS-1:0]          fault_vec_o,
  output logic                           uncache_o,
  output logic [VA_W-PG_SHIFT+CTX_W-1:0] tag_access_o
);
  localparam int LO_W = (2**SZ_W) - 1;

  logic   misaligned;
  fault_e code_d;
  logic   uc_d;

  acc_align_chk #(.SZ_W(SZ_W)) u_align (
    .va_lo_i     (va_i[LO_W-1:0]),
    .size_i      (size_i),
    .misaligned_o(misaligned)
  );

  acc_perm_chk u_perm (
    .misaligned_i(misaligned),
    .hit_i       (hit_i),
    .real_i      (real_i),
    .priv_i      (priv_i),
    .write_i     (write_i),
    .nf_asi_i    (nf_asi_i),
    .attr_i      (attr_i),
    .code_o      (code_d)
  );

  assign uc_d = (code_d == FLT_NONE) && (attr_i[ATTR_SIDE] || pa_i[UC_BIT]);

  acc_tag_reg #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .CTX_W(CTX_W)) u_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(req_valid_i && (code_d != FLT_NONE)),
    .va_i  (va_i),
    .ctx_i (ctx_i),
    .tag_o (tag_access_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      fault_code_o <= '0;
      uncache_o    <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      fault_code_o <= req_valid_i ? code_d : 3'd0;
      uncache_o    <= req_valid_i && uc_d;
    end
  end

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fault_vec_o[g] <= 1'b0;
      else         fault_vec_o[g] <= req_valid_i && (code_d == fault_e'(g + 1));
    end
  end
endmodule

// File: rtl/acc_fault_chk_sva.sv
module acc_fault_chk_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] va_i,
  input logic [1:0]  size_i,
  input logic        priv_i,
  input logic        hit_i,
  input logic [3:0]  attr_i,
  input logic        rsp_valid_o,
  input logic [2:0]  fault_code_o,
  input logic [6:0]  fault_vec_o,
  input logic        uncache_o,
  input logic [63:0] tag_access_o
);
  // R9
  vec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_vec_o));
  // R9
  vec_code_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vec_o == 7'd0) == (fault_code_o == 3'd0));
  // R1
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_i == 2'd3 && va_i[2:0] != 3'd0) |=> fault_code_o == 3'd1);
  // R3
  priv_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_i == 2'd0 && hit_i && !priv_i && attr_i[0]) |=> fault_code_o == 3'd4);
  // R7
  uc_only_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncache_o |-> (rsp_valid_o && fault_code_o == 3'd0));
  // R8
  tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && fault_code_o != 3'd0) |-> $stable(tag_access_o));
  // R9
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
endmodule

bind acc_fault_chk acc_fault_chk_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .va_i        (va_i),
  .size_i      (size_i),
  .priv_i      (priv_i),
  .hit_i       (hit_i),
  .attr_i      (attr_i),
  .rsp_valid_o (rsp_valid_o),
  .fault_code_o(fault_code_o),
  .fault_vec_o (fault_vec_o),
  .uncache_o   (uncache_o),
  .tag_access_o(tag_access_o)
);

// File: tb/acc_fault_chk_tb_top.sv
module acc_fault_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [1:0]  size_i = '0;
  logic        write_i = 1'b0, real_i = 1'b0, nf_asi_i = 1'b0, priv_i = 1'b0, hit_i = 1'b0;
  logic [3:0]  attr_i = '0;
  logic [39:0] pa_i = '0;
  logic [12:0] ctx_i = '0;
  logic        rsp_valid_o;
  logic [2:0]  fault_code_o;
  logic [6:0]  fault_vec_o;
  logic        uncache_o;
  logic [63:0] tag_access_o;

  int checks = 0;
  int fails = 0;
  logic [63:0] exp_tag = '0;

  always #4 clk_i = ~clk_i;

  acc_fault_chk dut_i (.*);

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr, rl, nf, pv, hit;
    logic [3:0]  attr;
    logic        pa39;
    logic [12:0] ctx;
    logic [2:0]  code;
    logic        uc;
  } vec_t;

  localparam int NV = 14;
  // attr: [3] side effect, [2] no-fault-only, [1] writable, [0] privileged
  localparam vec_t TBL [NV] = '{
    '{64'h0000_1234_5678_A000, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'b0010, 1'b0, 13'h011, 3'd0, 1'b0}, // R6 clean
    '{64'hFFFF_0000_0000_2004, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'b1111, 1'b1, 13'h0A5, 3'd1, 1'b0}, // R1
    '{64'h0000_0000_7654_3000, 2'd2, 1'b0,1'b1,1'b0,1'b1,1'b0, 4'b0010, 1'b0, 13'h1FF, 3'd2, 1'b0}, // R2 real
    '{64'h0000_00AB_CDEF_0010, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'b0010, 1'b0, 13'h003, 3'd3, 1'b0}, // R2 virt
    '{64'h0000_0000_0000_4000, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'b0001, 1'b0, 13'h044, 3'd4, 1'b0}, // R3 beats R4
    '{64'h0000_0000_0000_6008, 2'd3, 1'b1,1'b0,1'b0,1'b1,1'b1, 4'b0001, 1'b0, 13'h055, 3'd5, 1'b0}, // R4
    '{64'h0000_0000_0001_0002, 2'd1, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'b0100, 1'b0, 13'h066, 3'd5, 1'b0}, // R4 beats R5
    '{64'h0000_0000_0002_0000, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'b1110, 1'b0, 13'h077, 3'd6, 1'b0}, // R5
    '{64'h0000_0000_0003_0000, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'b0110, 1'b0, 13'h088, 3'd0, 1'b0}, // R5 nf ok
    '{64'h0000_0000_0004_0000, 2'd1, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'b1110, 1'b0, 13'h099, 3'd7, 1'b0}, // R6
    '{64'h0000_0000_0005_0000, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'b1010, 1'b0, 13'h0AA, 3'd0, 1'b1}, // R7 side
    '{64'h0000_0000_0006_0000, 2'd3, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'b0011, 1'b1, 13'h0BB, 3'd0, 1'b1}, // R7 pa
    '{64'h0000_0000_0007_0000, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'b1011, 1'b1, 13'h0CC, 3'd4, 1'b0}, // R7 no uc on fault
    '{64'h0000_0000_0008_0001, 2'd1, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'b0010, 1'b0, 13'h0DD, 3'd1, 1'b0}  // R1 halfword
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R9 reset state
    chk("R9 rst valid", {63'd0, rsp_valid_o}, 64'd0);
    chk("R9 rst code", {61'd0, fault_code_o}, 64'd0);
    chk("R9 rst tag", tag_access_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 idle", {63'd0, rsp_valid_o}, 64'd0);
    for (int i = 0; i < NV; i++) begin
      va_i = TBL[i].va; size_i = TBL[i].sz; write_i = TBL[i].wr; real_i = TBL[i].rl;
      nf_asi_i = TBL[i].nf; priv_i = TBL[i].pv; hit_i = TBL[i].hit; attr_i = TBL[i].attr;
      pa_i = {TBL[i].pa39, 39'h00_1234_5000}; ctx_i = TBL[i].ctx;
      req_valid_i = 1'b1;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      if (TBL[i].code != 3'd0) exp_tag = {TBL[i].va[63:13], TBL[i].ctx};
      chk($sformatf("R1-chain row%0d code", i), {61'd0, fault_code_o}, {61'd0, TBL[i].code});
      chk($sformatf("R9 row%0d valid", i), {63'd0, rsp_valid_o}, 64'd1);
      chk($sformatf("R9 row%0d vec", i), {57'd0, fault_vec_o},
          (TBL[i].code == 3'd0) ? 64'd0 : (64'd1 << (TBL[i].code - 3'd1)));
      chk($sformatf("R7 row%0d uc", i), {63'd0, uncache_o}, {63'd0, TBL[i].uc});
      chk($sformatf("R8 row%0d tag", i), tag_access_o, exp_tag);
      @(negedge clk_i);
      chk($sformatf("R9 row%0d one-cycle", i), {63'd0, rsp_valid_o}, 64'd0);
    end
    // R8 corner: idle cycle with fault-looking inputs leaves tag alone
    va_i = 64'hDEAD_BEEF_0000_0003; size_i = 2'd3; ctx_i = 13'h1AB;
    @(negedge clk_i);
    chk("R8 no request", tag_access_o, exp_tag);
    // R5 R6 corner: nf access on nfo + side page with priv page in priv mode
    va_i = 64'h0000_0000_0009_0000; size_i = 2'd3; nf_asi_i = 1'b1; priv_i = 1'b1;
    hit_i = 1'b1; attr_i = 4'b1111; write_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R6 last check", {61'd0, fault_code_o}, 64'd7);
    chk("R8 capture", tag_access_o, {va_i[63:13], ctx_i});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule